// File: doc/BRIEF.md
# SMI Request Generator with Broadcast Negotiation

This block turns byte writes to a power-management command port into system management interrupt (SMI) requests for a cluster of cores. Two command codes are reserved for switching the ACPI SCI enable on and off, and they never raise an SMI. Any other code raises one, provided the command-port SMI enable bit is set. The request is a single-cycle pulse on a per-core vector. It reaches either the core that issued the write or every core at once.

Firmware chooses between those two modes with a one-shot feature handshake. It writes a 64-bit request mask one byte at a time and then writes a confirm strobe. The block compares the request with a build-time supported mask. If no unsupported bit is present, it latches the request as the negotiated mask and raises a confirm flag. After that the negotiated set cannot change until reset. Bit 0 of the negotiated mask selects broadcast delivery.

The block also holds the SMI enable register. Bit 0 of that register is the global enable and is stored here. A lock bit, once set, makes both itself and bit 0 of the enable register read-only until reset.

Top module: `smi_hub`

## Requirements
- R1: A command-port write of `EN_CMD` (default 0xF1) sets `sci_en`, and a write of `DIS_CMD` (default 0xF0) clears it. Neither write produces any SMI pulse.
- R2: A command-port write of any other value pulses `smi_pulse` high for exactly the one cycle after the write. This happens only when bit `APM_EN_BIT` (default 5) of `smi_en` is 1. When that bit is 0, the vector stays all zero.
- R3: When bit 0 (broadcast) of `feat_neg` is 1, every bit of the SMI pulse is set. When it is 0, only bit `apm_core` is set.
- R4: A confirm write while `feat_ok` is 1 changes neither `feat_ok` nor `feat_neg`.
- R5: A confirm write whose request mask holds any bit outside `SUPPORTED` leaves `feat_ok` at 0 and `feat_neg` unchanged.
- R6: A confirm write whose request mask is a subset of `SUPPORTED` copies the request into `feat_neg` and sets `feat_ok` to 1, one cycle later.
- R7: Reset clears `feat_req`, `feat_ok`, `feat_neg`, `sci_en`, `smi_en`, `smi_lock` and `smi_pulse`. `SUPPORTED` is a parameter whose default holds only bit 0.
- R8: Once `smi_lock` is 1, writes can clear neither `smi_lock` nor bit 0 of `smi_en`. The other bits of `smi_en` stay writable. Before the lock is set, bit 0 of `smi_en` is writable.
- R9: A request-mask byte write with index i replaces bits 8i+7..8i of `feat_req` (little-endian) and leaves the other bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| apm_we | input | 1 | Command-port write strobe |
| apm_data | input | 8 | Command code |
| apm_core | input | CORE_W | Index of the writing core |
| smien_we | input | 1 | SMI enable register write strobe |
| smien_wdata | input | SMIEN_W | SMI enable write data |
| lock_we | input | 1 | Lock register write strobe |
| lock_wdata | input | 1 | Lock bit write value |
| freq_we | input | 1 | Request-mask byte write strobe |
| freq_idx | input | 3 | Byte lane index of the request-mask write |
| freq_byte | input | 8 | Request-mask byte value |
| fcfm_we | input | 1 | Confirm strobe |
| smi_pulse | output | NUM_CORES | Per-core SMI request pulses |
| sci_en | output | 1 | ACPI SCI enable |
| smi_en | output | SMIEN_W | SMI enable register |
| smi_lock | output | 1 | Lock bit |
| feat_req | output | 64 | Requested feature mask |
| feat_ok | output | 1 | Negotiation success flag |
| feat_neg | output | 64 | Negotiated feature mask |

## Verification
A wrong negotiated mask appears one cycle later in the shape of the next SMI pulse. A unicast pulse where a broadcast was due, or the reverse, is visible on the vector the cycle after the command write. A corrupted confirm flag appears at once on `feat_ok` and makes a later confirm either latch a new mask or fail to latch one. A lost lock, or a lock applied too early, appears on bit 0 of `smi_en` on the cycle after the next enable write.

// File: rtl/smi_pkg.sv
package smi_pkg;
  localparam int FEAT_W     = 64;
  localparam int FEAT_BYTES = FEAT_W / 8;
  localparam int BYTE_IW    = $clog2(FEAT_BYTES);
  localparam int BCAST_BIT  = 0;

  typedef logic [FEAT_W-1:0] feat_t;
  typedef logic [7:0]        cmd_t;

  function automatic logic is_subset(feat_t want, feat_t have);
    return (want & ~have) == '0;
  endfunction
endpackage

// File: rtl/smi_feat_negotiator.sv
module smi_feat_negotiator import smi_pkg::*; #(
  parameter feat_t SUPPORTED = feat_t'(1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_we,
  input  logic [BYTE_IW-1:0] req_idx,
  input  logic [7:0]         req_byte,
  input  logic               cfm_we,
  output feat_t              req_mask,
  output logic               ok,
  output feat_t              neg_mask
);
  feat_t req_q, req_d, neg_q, neg_d;
  logic  ok_q, ok_d;
  logic  accept;

  for (genvar b = 0; b < FEAT_BYTES; b++) begin : g_lane
    assign req_d[b*8 +: 8] = (req_we && req_idx == BYTE_IW'(b)) ? req_byte
                                                                 : req_q[b*8 +: 8];
  end

  assign accept = cfm_we && !ok_q && is_subset(req_q, SUPPORTED);

  always_comb begin
    ok_d  = ok_q;
    neg_d = neg_q;
    if (accept) begin
      ok_d  = 1'b1;
      neg_d = req_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      ok_q  <= 1'b0;
      neg_q <= '0;
    end else begin
      if (req_we) req_q <= req_d;
      if (accept) begin
        ok_q  <= ok_d;
        neg_q <= neg_d;
      end
    end
  end

  assign req_mask = req_q;
  assign ok       = ok_q;
  assign neg_mask = neg_q;
endmodule

// File: rtl/smi_en_lock.sv
module smi_en_lock #(
  parameter int SMIEN_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_we,
  input  logic [SMIEN_W-1:0] en_wdata,
  input  logic               lock_we,
  input  logic               lock_wdata,
  output logic [SMIEN_W-1:0] en,
  output logic               lock
);
  logic [SMIEN_W-1:0] en_q, en_d;
  logic               lock_q, lock_d;

  always_comb begin
    en_d = en_wdata;
    if (lock_q) en_d[0] = en_q[0];
    lock_d = lock_q | lock_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      lock_q <= 1'b0;
    end else begin
      if (en_we)   en_q   <= en_d;
      if (lock_we) lock_q <= lock_d;
    end
  end

  assign en   = en_q;
  assign lock = lock_q;
endmodule

// File: rtl/smi_apm_decode.sv
module smi_apm_decode import smi_pkg::*; #(
  parameter int   NUM_CORES = 4,
  parameter int   CORE_W    = 2,
  parameter cmd_t EN_CMD    = 8'hF1,
  parameter cmd_t DIS_CMD   = 8'hF0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 apm_we,
  input  cmd_t                 apm_data,
  input  logic [CORE_W-1:0]    apm_core,
  input  logic                 apm_smi_en,
  input  logic                 bcast,
  output logic                 sci_en,
  output logic [NUM_CORES-1:0] smi_pulse
);
  logic                 sci_q, sci_d;
  logic [NUM_CORES-1:0] pulse_q, pulse_d, hit;
  logic                 is_en, is_dis, fire;

  assign is_en  = apm_data == EN_CMD;
  assign is_dis = apm_data == DIS_CMD;
  assign fire   = apm_we && !is_en && !is_dis && apm_smi_en;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign hit[c] = bcast || (apm_core == CORE_W'(c));
  end

  always_comb begin
    sci_d = sci_q;
    if (apm_we && is_en)  sci_d = 1'b1;
    if (apm_we && is_dis) sci_d = 1'b0;
    pulse_d = fire ? hit : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sci_q   <= 1'b0;
      pulse_q <= '0;
    end else begin
      sci_q   <= sci_d;
      pulse_q <= pulse_d;
    end
  end

  assign sci_en    = sci_q;
  assign smi_pulse = pulse_q;
endmodule

// File: rtl/smi_hub.sv
module smi_hub import smi_pkg::*; #(
  parameter int    NUM_CORES  = 4,
  parameter int    CORE_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  parameter int    SMIEN_W    = 32,
  parameter int    APM_EN_BIT = 5,
  parameter cmd_t  EN_CMD     = 8'hF1,
  parameter cmd_t  DIS_CMD    = 8'hF0,
  parameter feat_t SUPPORTED  = feat_t'(1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 apm_we,
  input  logic [7:0]           apm_data,
  input  logic [CORE_W-1:0]    apm_core,
  input  logic                 smien_we,
  input  logic [SMIEN_W-1:0]   smien_wdata,
  input  logic                 lock_we,
  input  logic                 lock_wdata,
  input  logic                 freq_we,
  input  logic [BYTE_IW-1:0]   freq_idx,
  input  logic [7:0]           freq_byte,
  input  logic                 fcfm_we,
  output logic [NUM_CORES-1:0] smi_pulse,
  output logic                 sci_en,
  output logic [SMIEN_W-1:0]   smi_en,
  output logic                 smi_lock,
  output logic [FEAT_W-1:0]    feat_req,
  output logic                 feat_ok,
  output logic [FEAT_W-1:0]    feat_neg
);
  feat_t neg_w;

  smi_feat_negotiator #(.SUPPORTED(SUPPORTED)) u_neg (
    .clk(clk), .rst_n(rst_n),
    .req_we(freq_we), .req_idx(freq_idx), .req_byte(freq_byte),
    .cfm_we(fcfm_we),
    .req_mask(feat_req), .ok(feat_ok), .neg_mask(neg_w)
  );

  smi_en_lock #(.SMIEN_W(SMIEN_W)) u_en (
    .clk(clk), .rst_n(rst_n),
    .en_we(smien_we), .en_wdata(smien_wdata),
    .lock_we(lock_we), .lock_wdata(lock_wdata),
    .en(smi_en), .lock(smi_lock)
  );

  smi_apm_decode #(
    .NUM_CORES(NUM_CORES), .CORE_W(CORE_W),
    .EN_CMD(EN_CMD), .DIS_CMD(DIS_CMD)
  ) u_apm (
    .clk(clk), .rst_n(rst_n),
    .apm_we(apm_we), .apm_data(apm_data), .apm_core(apm_core),
    .apm_smi_en(smi_en[APM_EN_BIT]), .bcast(neg_w[BCAST_BIT]),
    .sci_en(sci_en), .smi_pulse(smi_pulse)
  );

  assign feat_neg = neg_w;
endmodule

// File: rtl/smi_hub_chk.sv
module smi_hub_chk import smi_pkg::*; #(
  parameter int    NUM_CORES  = 4,
  parameter int    CORE_W     = 2,
  parameter int    SMIEN_W    = 32,
  parameter int    APM_EN_BIT = 5,
  parameter cmd_t  EN_CMD     = 8'hF1,
  parameter cmd_t  DIS_CMD    = 8'hF0,
  parameter feat_t SUPPORTED  = feat_t'(1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 apm_we,
  input logic [7:0]           apm_data,
  input logic [NUM_CORES-1:0] smi_pulse,
  input logic [SMIEN_W-1:0]   smi_en,
  input logic                 smi_lock,
  input logic                 feat_ok,
  input logic [FEAT_W-1:0]    feat_neg
);
  AST_CMD_NO_SMI: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(apm_we) && ($past(apm_data) == EN_CMD || $past(apm_data) == DIS_CMD))
      |-> smi_pulse == '0); // R1

  AST_PULSE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_pulse != '0) |-> ($past(apm_we) && $past(smi_en[APM_EN_BIT]))); // R2

  AST_UNICAST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_pulse != '0 && !$past(feat_neg[BCAST_BIT])) |-> $countones(smi_pulse) == 1); // R3

  AST_NEG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    feat_ok |=> (feat_ok && $stable(feat_neg))); // R4

  AST_NEG_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    feat_ok |-> (feat_neg & ~SUPPORTED) == '0); // R5

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    smi_lock |=> (smi_lock && $stable(smi_en[0]))); // R8
endmodule

bind smi_hub smi_hub_chk #(
  .NUM_CORES(NUM_CORES), .CORE_W(CORE_W), .SMIEN_W(SMIEN_W),
  .APM_EN_BIT(APM_EN_BIT), .EN_CMD(EN_CMD), .DIS_CMD(DIS_CMD),
  .SUPPORTED(SUPPORTED)
) u_chk (
  .clk(clk), .rst_n(rst_n), .apm_we(apm_we), .apm_data(apm_data),
  .smi_pulse(smi_pulse), .smi_en(smi_en), .smi_lock(smi_lock),
  .feat_ok(feat_ok), .feat_neg(feat_neg)
);

// File: tb/smi_hub_test.sv
`timescale 1ns/1ps
module smi_hub_test;
  localparam int NC = 4;
  localparam int CW = 2;
  localparam int EW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          apm_we = 1'b0;
  logic [7:0]    apm_data = '0;
  logic [CW-1:0] apm_core = '0;
  logic          smien_we = 1'b0;
  logic [EW-1:0] smien_wdata = '0;
  logic          lock_we = 1'b0;
  logic          lock_wdata = 1'b0;
  logic          freq_we = 1'b0;
  logic [2:0]    freq_idx = '0;
  logic [7:0]    freq_byte = '0;
  logic          fcfm_we = 1'b0;
  logic [NC-1:0] smi_pulse;
  logic          sci_en, smi_lock, feat_ok;
  logic [EW-1:0] smi_en;
  logic [63:0]   feat_req, feat_neg;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic apm_seen = 1'b0;
  logic [NC-1:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  smi_hub uut (
    .clk(clk), .rst_n(rst_n), .apm_we(apm_we), .apm_data(apm_data),
    .apm_core(apm_core), .smien_we(smien_we), .smien_wdata(smien_wdata),
    .lock_we(lock_we), .lock_wdata(lock_wdata), .freq_we(freq_we),
    .freq_idx(freq_idx), .freq_byte(freq_byte), .fcfm_we(fcfm_we),
    .smi_pulse(smi_pulse), .sci_en(sci_en), .smi_en(smi_en),
    .smi_lock(smi_lock), .feat_req(feat_req), .feat_ok(feat_ok),
    .feat_neg(feat_neg)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the expected SMI vector the cycle after each command write
  always @(posedge clk) apm_seen <= apm_we;
  always @(negedge clk) begin
    if (apm_seen && exp_q.size() > 0) begin
      logic [NC-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, 64'(smi_pulse), 64'(e));
    end
  end

  task automatic apm(input logic [7:0] d, input int core, input logic [NC-1:0] e, input string t);
    @(negedge clk);
    apm_we = 1'b1; apm_data = d; apm_core = CW'(core);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    apm_we = 1'b0;
    @(negedge clk);
    chk({t, " pulse gone"}, 64'(smi_pulse), 64'h0);
  endtask

  task automatic wr_en(input logic [EW-1:0] d);
    @(negedge clk); smien_we = 1'b1; smien_wdata = d;
    @(negedge clk); smien_we = 1'b0;
  endtask

  task automatic wr_lock(input logic d);
    @(negedge clk); lock_we = 1'b1; lock_wdata = d;
    @(negedge clk); lock_we = 1'b0;
  endtask

  task automatic wr_req(input int idx, input logic [7:0] b);
    @(negedge clk); freq_we = 1'b1; freq_idx = 3'(idx); freq_byte = b;
    @(negedge clk); freq_we = 1'b0;
  endtask

  task automatic confirm();
    @(negedge clk); fcfm_we = 1'b1;
    @(negedge clk); fcfm_we = 1'b0;
  endtask

  task automatic reset_checks(input string t);
    chk({t, " feat_req"}, feat_req, 64'h0);
    chk({t, " feat_ok"}, 64'(feat_ok), 64'h0);
    chk({t, " feat_neg"}, feat_neg, 64'h0);
    chk({t, " sci_en"}, 64'(sci_en), 64'h0);
    chk({t, " smi_en"}, 64'(smi_en), 64'h0);
    chk({t, " smi_lock"}, 64'(smi_lock), 64'h0);
    chk({t, " smi_pulse"}, 64'(smi_pulse), 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reset_checks("R7 reset");

    apm(8'hB2, 1, 4'b0000, "R2 apm bit clear");
    wr_en(32'h21);
    chk("R8 bit0 writable", 64'(smi_en), 64'h21);
    apm(8'hB2, 2, 4'b0100, "R3 unicast core2");

    apm(8'hF1, 3, 4'b0000, "R1 enable cmd");
    chk("R1 sci set", 64'(sci_en), 64'h1);
    apm(8'hF0, 3, 4'b0000, "R1 disable cmd");
    chk("R1 sci clear", 64'(sci_en), 64'h0);

    wr_req(0, 8'h03);
    chk("R9 byte0", feat_req, 64'h3);
    wr_req(7, 8'h80);
    chk("R9 byte7", feat_req, 64'h8000_0000_0000_0003);
    confirm();
    chk("R5 ok stays 0", 64'(feat_ok), 64'h0);
    chk("R5 neg unchanged", feat_neg, 64'h0);
    apm(8'h55, 1, 4'b0010, "R3 unicast core1");

    wr_req(7, 8'h00);
    wr_req(0, 8'h01);
    chk("R9 rewrite", feat_req, 64'h1);
    confirm();
    chk("R6 ok set", 64'(feat_ok), 64'h1);
    chk("R6 neg latched", feat_neg, 64'h1);
    apm(8'hB2, 0, 4'b1111, "R3 broadcast");

    wr_req(0, 8'h00);
    confirm();
    chk("R4 ok held", 64'(feat_ok), 64'h1);
    chk("R4 neg held", feat_neg, 64'h1);
    apm(8'hB2, 3, 4'b1111, "R4 still broadcast");

    wr_en(32'h20);
    chk("R8 bit0 clear before lock", 64'(smi_en), 64'h20);
    wr_en(32'h21);
    wr_lock(1'b1);
    chk("R8 lock set", 64'(smi_lock), 64'h1);
    wr_en(32'h60);
    chk("R8 bit0 held, others written", 64'(smi_en), 64'h61);
    wr_lock(1'b0);
    chk("R8 lock sticky", 64'(smi_lock), 64'h1);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    reset_checks("R7 second reset");
    apm(8'hB2, 0, 4'b0000, "R7 no smi after reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule